// File: doc/BRIEF.md
# Sliding-Window CFAR Detector

This block makes the detection decision for one column of range cells. A pulse on `frame_start_i` opens a frame. The block then takes exactly `NCELLS` magnitude samples into a small on-chip store. When the adaptive path is enabled, it walks the stored column one cell at a time. For each cell it forms a noise estimate from the training cells that lie on both sides of the cell under test. The guard cells next to the cell under test are skipped. The cell is flagged when its magnitude exceeds the noise estimate scaled by a programmable multiplier.

The estimate can be the mean of both sides, the greater of the two side means, or the smaller of the two side means. When the adaptive path is disabled, every incoming sample is compared against a fixed threshold as it arrives. The block latches all configuration inputs when a frame starts. Each decision leaves on a valid/flag/index stream. A running count of flagged cells covers the current frame only.

The controller steps through these states:
- `ST_IDLE`: waiting. A start pulse moves it to `ST_BUFFER`.
- `ST_BUFFER`: loading samples. After the last sample it goes to `ST_THR` when adaptive, or to `ST_DONE` in bypass.
- Per-cell loop: `ST_THR` registers the mode-selected noise sum and cell count. `ST_MUL` forms both products. `ST_CMP` decides and slides the window. From `ST_CMP` it returns to `ST_THR`, or goes to `ST_DONE` after the last cell.
- `ST_DONE`: clears the count and returns to `ST_IDLE`.

Top module: `cfar_top`

## Requirements
- R1: After reset `busy_o`, `det_valid_o` and `det_flag_o` are low and `det_count_o` is zero.
- R2: A `frame_start_i` pulse in idle starts a frame and latches enable, mode, guard, training, alpha and fixed threshold. Configuration changes and start pulses while busy have no effect on that frame.
- R3: In the load phase the block accepts exactly `NCELLS` samples, one per cycle with `mag_valid_i` high, stored in arrival order as cells 0 to `NCELLS`-1. Idle cycles between samples are allowed, and every cell receives exactly one decision.
- R4: With enable low, each accepted sample yields a decision one cycle later: flag = sample > fixed threshold (unsigned), index = sample position. The frame ends after the last sample. `det_flag_o` is high only together with `det_valid_o`.
- R5: With enable high, decisions are made for cells 0 to `NCELLS`-1 in order, exactly three cycles apart.
- R6: For cell c with guard G and training T, the lagging cells are c-G-T to c-G-1 and the leading cells are c+G+1 to c+G+T. Cells outside 0 to `NCELLS`-1 are left out, and so are the guard cells and the cell under test.
- R7: Mode 0 (mean of both sides) flags when cut·(nL+nR)·16 > alpha·(sumL+sumR). Alpha is unsigned with 4 fractional bits, and mode 3 behaves as mode 0.
- R8: Mode 1 (greater-of) uses the side whose mean is larger, compared as sumL·nR against sumR·nL. It flags when cut·n·16 > alpha·sum for that side, and a side with no cells is never chosen.
- R9: Mode 2 (smaller-of) is the same as mode 1 but uses the side with the smaller mean.
- R10: A cell with no training cells on either side is never flagged.
- R11: `det_count_o` rises by one in the cycle of each flagged decision and holds otherwise. It is cleared on leaving `ST_DONE`, so it is zero whenever the block is idle.
- R12: `busy_o` is high from the cycle after the accepted start until the cycle after the frame's final decision.
- R13: Identical frames with identical configuration produce identical flags and identical counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start_i | input | 1 | Start-of-frame pulse |
| mag_valid_i | input | 1 | Sample strobe |
| mag_i | input | MAG_W | Magnitude sample |
| cfg_enable_i | input | 1 | 1 = adaptive detection, 0 = fixed threshold |
| cfg_mode_i | input | 2 | 0 mean, 1 greater-of, 2 smaller-of, 3 mean |
| cfg_guard_i | input | GUARD_W | Guard cells per side |
| cfg_train_i | input | TRAIN_W | Training cells per side |
| cfg_alpha_i | input | ALPHA_W | Threshold multiplier, 4 fractional bits |
| cfg_fixed_thr_i | input | MAG_W | Fixed threshold for bypass |
| det_valid_o | output | 1 | Decision strobe |
| det_flag_o | output | 1 | Cell detected |
| det_index_o | output | IDX_W | Cell index of the decision |
| busy_o | output | 1 | Frame in progress |
| det_count_o | output | CNT_W | Detections so far in this frame |

## Verification
Two functions can fall in the same cycle. In every frame, the final decision, which may bump the count, is followed at once by the clear in `ST_DONE`. In adaptive frames, the window slide shares an edge with the decision write. The bench provokes both with flagged cells at indices 0 and `NCELLS`-1, and with windows larger than the column. It then checks, in the cycle the last decision appears, that the count includes it. It also checks that, at the falling edge of busy, the count reads zero while the frame total matches the reference. Start pulses and configuration changes are also injected mid-frame, and the frame's decisions must still match the values latched at the start.

// File: rtl/cfar_pkg.sv
package cfar_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BUFFER,
        ST_THR,
        ST_MUL,
        ST_CMP,
        ST_DONE
    } cfar_state_t;

    localparam logic [1:0] AVG_MEAN    = 2'd0;
    localparam logic [1:0] AVG_GREATER = 2'd1;
    localparam logic [1:0] AVG_SMALLER = 2'd2;

endpackage

// File: rtl/cfar_mag_store.sv
module cfar_mag_store #(
    parameter int MAG_W = 16,
    parameter int DEPTH = 32,
    parameter int NRD   = 5,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 wr_en,
    input  logic [AW-1:0]        wr_addr,
    input  logic [MAG_W-1:0]     wr_data,
    input  logic [NRD*AW-1:0]    rd_addr,
    output logic [NRD*MAG_W-1:0] rd_data
);

    logic [MAG_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            cells[wr_addr] <= wr_data;
        end
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rd_data[g*MAG_W +: MAG_W] = cells[rd_addr[g*AW +: AW]];
    end

endmodule

// File: rtl/cfar_side_acc.sv
module cfar_side_acc #(
    parameter int MAG_W = 16,
    parameter int SUM_W = 20,
    parameter int NC_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             add_en,
    input  logic [MAG_W-1:0] add_val,
    input  logic             rem_en,
    input  logic [MAG_W-1:0] rem_val,
    output logic [SUM_W-1:0] sum_o,
    output logic [NC_W-1:0]  cnt_o
);

    logic [SUM_W-1:0] add_ext, rem_ext;
    logic [NC_W-1:0]  add_one, rem_one;

    always_comb begin
        add_ext = add_en ? SUM_W'(add_val) : '0;
        rem_ext = rem_en ? SUM_W'(rem_val) : '0;
        add_one = add_en ? NC_W'(1) : '0;
        rem_one = rem_en ? NC_W'(1) : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            sum_o <= '0;
            cnt_o <= '0;
        end else begin
            sum_o <= sum_o + add_ext - rem_ext;
            cnt_o <= cnt_o + add_one - rem_one;
        end
    end

endmodule

// File: rtl/cfar_noise_sel.sv
module cfar_noise_sel
    import cfar_pkg::*;
#(
    parameter int SUM_W = 20,
    parameter int NC_W  = 4
) (
    input  logic [1:0]       mode,
    input  logic [SUM_W-1:0] lag_sum,
    input  logic [NC_W-1:0]  lag_cnt,
    input  logic [SUM_W-1:0] lead_sum,
    input  logic [NC_W-1:0]  lead_cnt,
    output logic [SUM_W:0]   num_o,
    output logic [NC_W:0]    den_o
);

    localparam int XW = SUM_W + NC_W;

    logic [XW-1:0] lag_x, lead_x;
    logic          use_lag;

    // Side means compared without division: sumL*nR vs sumR*nL.
    assign lag_x  = XW'(lag_sum)  * XW'(lead_cnt);
    assign lead_x = XW'(lead_sum) * XW'(lag_cnt);

    always_comb begin
        if (lag_cnt == '0) begin
            use_lag = 1'b0;
        end else if (lead_cnt == '0) begin
            use_lag = 1'b1;
        end else if (mode == AVG_GREATER) begin
            use_lag = (lag_x >= lead_x);
        end else begin
            use_lag = (lag_x <= lead_x);
        end

        if (mode == AVG_GREATER || mode == AVG_SMALLER) begin
            num_o = use_lag ? {1'b0, lag_sum} : {1'b0, lead_sum};
            den_o = use_lag ? {1'b0, lag_cnt} : {1'b0, lead_cnt};
        end else begin
            num_o = {1'b0, lag_sum} + {1'b0, lead_sum};
            den_o = {1'b0, lag_cnt} + {1'b0, lead_cnt};
        end
    end

endmodule

// File: rtl/cfar_top.sv
module cfar_top
    import cfar_pkg::*;
#(
    parameter int MAG_W      = 16,
    parameter int NCELLS     = 32,
    parameter int GUARD_W    = 3,
    parameter int TRAIN_W    = 4,
    parameter int ALPHA_W    = 8,
    parameter int ALPHA_FRAC = 4,
    parameter int CNT_W      = 16,
    parameter int IDX_W      = $clog2(NCELLS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_start_i,
    input  logic               mag_valid_i,
    input  logic [MAG_W-1:0]   mag_i,
    input  logic               cfg_enable_i,
    input  logic [1:0]         cfg_mode_i,
    input  logic [GUARD_W-1:0] cfg_guard_i,
    input  logic [TRAIN_W-1:0] cfg_train_i,
    input  logic [ALPHA_W-1:0] cfg_alpha_i,
    input  logic [MAG_W-1:0]   cfg_fixed_thr_i,
    output logic               det_valid_o,
    output logic               det_flag_o,
    output logic [IDX_W-1:0]   det_index_o,
    output logic               busy_o,
    output logic [CNT_W-1:0]   det_count_o
);

    localparam int SUM_W  = MAG_W + TRAIN_W;
    localparam int NC_W   = TRAIN_W;
    localparam int NUM_W  = SUM_W + 1;
    localparam int DEN_W  = NC_W + 1;
    localparam int PROD_W = ALPHA_W + NUM_W;
    localparam int LHS_W  = MAG_W + DEN_W + ALPHA_FRAC;
    localparam int CMP_W  = (PROD_W > LHS_W) ? PROD_W : LHS_W;
    localparam int NRD    = 5;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NCELLS - 1);

    cfar_state_t state, state_nx;

    // Latched configuration
    logic               cfg_en_q;
    logic [1:0]         mode_q;
    logic [GUARD_W-1:0] guard_q;
    logic [TRAIN_W-1:0] train_q;
    logic [ALPHA_W-1:0] alpha_q;
    logic [MAG_W-1:0]   thr_q;

    logic [IDX_W-1:0] wr_idx, cut_idx;
    logic             accept;

    // Pipeline registers of the per-cell loop
    logic [NUM_W-1:0]  num_q;
    logic [DEN_W-1:0]  den_q;
    logic [PROD_W-1:0] prod_q;
    logic [LHS_W-1:0]  lhs_q;
    logic              den_nz_q;
    logic              hit;

    // Window bookkeeping
    logic [NRD*IDX_W-1:0] rd_addr;
    logic [NRD*MAG_W-1:0] rd_data;
    logic [MAG_W-1:0]     cut_mag, lag_add_mag, lag_rem_mag, lead_rem_mag, lead_add_mag;
    logic [IDX_W-1:0]     lag_add_a, lag_rem_a, lead_rem_a, lead_add_a;
    logic                 lag_add_ok, lag_rem_ok, lead_rem_ok, lead_add_ok;
    logic                 preload;
    logic                 win_step;
    logic                 lead_add_en;
    logic [MAG_W-1:0]     lead_add_val;
    logic [SUM_W-1:0]     lag_sum, lead_sum;
    logic [NC_W-1:0]      lag_cnt, lead_cnt;
    logic [NUM_W-1:0]     sel_num;
    logic [DEN_W-1:0]     sel_den;

    assign accept   = (state == ST_BUFFER) && mag_valid_i;
    assign busy_o   = (state != ST_IDLE);
    assign win_step = (state == ST_CMP);

    // ---------------- state register ----------------
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (frame_start_i) state_nx = ST_BUFFER;
            ST_BUFFER: if (accept && wr_idx == LAST) state_nx = cfg_en_q ? ST_THR : ST_DONE;
            ST_THR:    state_nx = ST_MUL;
            ST_MUL:    state_nx = ST_CMP;
            ST_CMP:    state_nx = (cut_idx == LAST) ? ST_DONE : ST_THR;
            ST_DONE:   state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // ---------------- window positions ----------------
    always_comb begin
        int c, g, t, p_la, p_lr, p_dr, p_da, p_w;
        c    = int'(cut_idx);
        g    = int'(guard_q);
        t    = int'(train_q);
        p_la = c - g;
        p_lr = c - g - t;
        p_dr = c + g + 1;
        p_da = c + g + t + 1;
        p_w  = int'(wr_idx);
        lag_add_ok  = (p_la >= 0);
        lag_rem_ok  = (p_lr >= 0);
        lead_rem_ok = (p_dr < NCELLS);
        lead_add_ok = (p_da < NCELLS);
        lag_add_a   = lag_add_ok  ? IDX_W'(p_la) : '0;
        lag_rem_a   = lag_rem_ok  ? IDX_W'(p_lr) : '0;
        lead_rem_a  = lead_rem_ok ? IDX_W'(p_dr) : '0;
        lead_add_a  = lead_add_ok ? IDX_W'(p_da) : '0;
        preload     = accept && cfg_en_q && (p_w >= g + 1) && (p_w <= g + t);
    end

    assign rd_addr = {lead_add_a, lead_rem_a, lag_rem_a, lag_add_a, cut_idx};
    assign cut_mag      = rd_data[0*MAG_W +: MAG_W];
    assign lag_add_mag  = rd_data[1*MAG_W +: MAG_W];
    assign lag_rem_mag  = rd_data[2*MAG_W +: MAG_W];
    assign lead_rem_mag = rd_data[3*MAG_W +: MAG_W];
    assign lead_add_mag = rd_data[4*MAG_W +: MAG_W];

    assign lead_add_en  = preload || (win_step && lead_add_ok);
    assign lead_add_val = preload ? mag_i : lead_add_mag;

    cfar_mag_store #(
        .MAG_W (MAG_W),
        .DEPTH (NCELLS),
        .NRD   (NRD),
        .AW    (IDX_W)
    ) u_store (
        .clk     (clk),
        .wr_en   (accept),
        .wr_addr (wr_idx),
        .wr_data (mag_i),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    cfar_side_acc #(
        .MAG_W (MAG_W),
        .SUM_W (SUM_W),
        .NC_W  (NC_W)
    ) u_lag (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (state == ST_IDLE),
        .add_en  (win_step && lag_add_ok),
        .add_val (lag_add_mag),
        .rem_en  (win_step && lag_rem_ok),
        .rem_val (lag_rem_mag),
        .sum_o   (lag_sum),
        .cnt_o   (lag_cnt)
    );

    cfar_side_acc #(
        .MAG_W (MAG_W),
        .SUM_W (SUM_W),
        .NC_W  (NC_W)
    ) u_lead (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (state == ST_IDLE),
        .add_en  (lead_add_en),
        .add_val (lead_add_val),
        .rem_en  (win_step && lead_rem_ok),
        .rem_val (lead_rem_mag),
        .sum_o   (lead_sum),
        .cnt_o   (lead_cnt)
    );

    cfar_noise_sel #(
        .SUM_W (SUM_W),
        .NC_W  (NC_W)
    ) u_sel (
        .mode     (mode_q),
        .lag_sum  (lag_sum),
        .lag_cnt  (lag_cnt),
        .lead_sum (lead_sum),
        .lead_cnt (lead_cnt),
        .num_o    (sel_num),
        .den_o    (sel_den)
    );

    // ---------------- datapath registers ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_en_q <= 1'b0;
            mode_q   <= '0;
            guard_q  <= '0;
            train_q  <= '0;
            alpha_q  <= '0;
            thr_q    <= '0;
            wr_idx   <= '0;
            cut_idx  <= '0;
            num_q    <= '0;
            den_q    <= '0;
            prod_q   <= '0;
            lhs_q    <= '0;
            den_nz_q <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (frame_start_i) begin
                        cfg_en_q <= cfg_enable_i;
                        mode_q   <= cfg_mode_i;
                        guard_q  <= cfg_guard_i;
                        train_q  <= cfg_train_i;
                        alpha_q  <= cfg_alpha_i;
                        thr_q    <= cfg_fixed_thr_i;
                        wr_idx   <= '0;
                        cut_idx  <= '0;
                    end
                end
                ST_BUFFER: begin
                    if (accept && wr_idx != LAST) wr_idx <= wr_idx + 1'b1;
                end
                ST_THR: begin
                    num_q <= sel_num;
                    den_q <= sel_den;
                end
                ST_MUL: begin
                    prod_q   <= PROD_W'(alpha_q) * PROD_W'(num_q);
                    lhs_q    <= (LHS_W'(cut_mag) * LHS_W'(den_q)) << ALPHA_FRAC;
                    den_nz_q <= (den_q != '0);
                end
                ST_CMP: begin
                    if (cut_idx != LAST) cut_idx <= cut_idx + 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign hit = den_nz_q && (CMP_W'(lhs_q) > CMP_W'(prod_q));

    // ---------------- outputs ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            det_valid_o <= 1'b0;
            det_flag_o  <= 1'b0;
            det_index_o <= '0;
            det_count_o <= '0;
        end else begin
            det_valid_o <= 1'b0;
            det_flag_o  <= 1'b0;
            unique case (state)
                ST_BUFFER: begin
                    if (accept && !cfg_en_q) begin
                        det_valid_o <= 1'b1;
                        det_flag_o  <= (mag_i > thr_q);
                        det_index_o <= wr_idx;
                        det_count_o <= det_count_o + CNT_W'(mag_i > thr_q);
                    end
                end
                ST_CMP: begin
                    det_valid_o <= 1'b1;
                    det_flag_o  <= hit;
                    det_index_o <= cut_idx;
                    det_count_o <= det_count_o + CNT_W'(hit);
                end
                ST_DONE: det_count_o <= '0;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/cfar_checker.sv
module cfar_checker #(
    parameter int IDX_W = 5,
    parameter int CNT_W = 16,
    parameter int LAST  = 31
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frame_start_i,
    input logic             busy_o,
    input logic             det_valid_o,
    input logic             det_flag_o,
    input logic [IDX_W-1:0] det_index_o,
    input logic [CNT_W-1:0] det_count_o,
    input logic             cfg_en_q
);

    a_r2_start_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && frame_start_i) |=> busy_o);

    a_r4_flag_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        det_flag_o |-> det_valid_o);

    a_r5_decision_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (det_valid_o && cfg_en_q) |=> (!det_valid_o ##1 !det_valid_o));

    a_r11_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        det_valid_o |-> det_count_o == $past(det_count_o) + CNT_W'(det_flag_o));

    a_r11_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !det_valid_o) |-> $stable(det_count_o));

    a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> det_count_o == '0);

    a_r12_busy_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> ($past(det_valid_o) && $past(det_index_o) == IDX_W'(LAST)));

endmodule

bind cfar_top cfar_checker #(
    .IDX_W (IDX_W),
    .CNT_W (CNT_W),
    .LAST  (NCELLS - 1)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_start_i (frame_start_i),
    .busy_o        (busy_o),
    .det_valid_o   (det_valid_o),
    .det_flag_o    (det_flag_o),
    .det_index_o   (det_index_o),
    .det_count_o   (det_count_o),
    .cfg_en_q      (cfg_en_q)
);

// File: tb/sim_cfar_top.sv
module sim_cfar_top;

    localparam int N = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start_i = 1'b0;
    logic        mag_valid_i = 1'b0;
    logic [15:0] mag_i = '0;
    logic        cfg_enable_i = 1'b0;
    logic [1:0]  cfg_mode_i = '0;
    logic [2:0]  cfg_guard_i = '0;
    logic [3:0]  cfg_train_i = '0;
    logic [7:0]  cfg_alpha_i = '0;
    logic [15:0] cfg_fixed_thr_i = '0;
    logic        det_valid_o, det_flag_o, busy_o;
    logic [4:0]  det_index_o;
    logic [15:0] det_count_o;

    always #2.5 clk = ~clk;

    cfar_top u0 (
        .clk(clk), .rst_n(rst_n), .frame_start_i(frame_start_i),
        .mag_valid_i(mag_valid_i), .mag_i(mag_i), .cfg_enable_i(cfg_enable_i),
        .cfg_mode_i(cfg_mode_i), .cfg_guard_i(cfg_guard_i), .cfg_train_i(cfg_train_i),
        .cfg_alpha_i(cfg_alpha_i), .cfg_fixed_thr_i(cfg_fixed_thr_i),
        .det_valid_o(det_valid_o), .det_flag_o(det_flag_o), .det_index_o(det_index_o),
        .busy_o(busy_o), .det_count_o(det_count_o)
    );

    typedef struct { int idx; bit flag; } exp_t;
    exp_t  exp_q[$];
    int    tot_q[$];
    int    d[N];
    int    n_checks = 0;
    int    n_errors = 0;
    string tag = "R1";
    bit    frame_cfar = 1'b0;
    int    mon_last_total = -1;
    longint cyc = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    function automatic bit ref_cfar(int c, int g, int t, int a, int mode);
        longint ls = 0, rs = 0, num, den;
        int nl = 0, nr = 0;
        bit left;
        for (int j = c - g - t; j <= c - g - 1; j++) if (j >= 0) begin ls += d[j]; nl++; end
        for (int j = c + g + 1; j <= c + g + t; j++) if (j < N) begin rs += d[j]; nr++; end
        if (mode == 1 || mode == 2) begin
            if (nl == 0) left = 0;
            else if (nr == 0) left = 1;
            else if (mode == 1) left = (ls * nr >= rs * nl);
            else left = (ls * nr <= rs * nl);
            num = left ? ls : rs;
            den = left ? nl : nr;
        end else begin
            num = ls + rs;
            den = nl + nr;
        end
        if (den == 0) return 1'b0;
        return (longint'(d[c]) * den * 16) > (longint'(a) * num);
    endfunction

    // Driver: pushes expected decisions, then plays the frame.
    task automatic run_frame(input bit en, input int mode, input int g, input int t,
                             input int a, input int thr, input int gap,
                             input bit disturb, input string req);
        int total = 0;
        for (int c = 0; c < N; c++) begin
            exp_t e;
            e.idx  = c;
            e.flag = en ? ref_cfar(c, g, t, a, mode) : (d[c] > thr);
            total += e.flag;
            exp_q.push_back(e);
        end
        tot_q.push_back(total);
        tag = req;
        frame_cfar = en;
        cfg_enable_i = en; cfg_mode_i = 2'(mode); cfg_guard_i = 3'(g);
        cfg_train_i = 4'(t); cfg_alpha_i = 8'(a); cfg_fixed_thr_i = 16'(thr);
        @(posedge clk); #1;
        chk(busy_o == 1'b0, "R12", "busy before start", busy_o, 0);
        frame_start_i = 1'b1;
        @(posedge clk); #1;
        frame_start_i = 1'b0;
        chk(busy_o == 1'b1, "R12", "busy after start", busy_o, 1);
        for (int i = 0; i < N; i++) begin
            mag_valid_i = 1'b1;
            mag_i = 16'(d[i]);
            if (disturb && i == 10) begin
                frame_start_i = 1'b1;
                cfg_enable_i = ~en; cfg_mode_i = 2'(mode + 1); cfg_guard_i = 3'(g + 1);
                cfg_alpha_i = 8'd1; cfg_fixed_thr_i = 16'd0;
            end
            @(posedge clk); #1;
            mag_valid_i = 1'b0;
            frame_start_i = 1'b0;
            mag_i = 16'hDEAD;
            repeat (gap) begin @(posedge clk); #1; end
        end
        if (disturb) begin
            frame_start_i = 1'b1;
            @(posedge clk); #1;
            frame_start_i = 1'b0;
        end
        do @(negedge clk); while (busy_o);
        repeat (2) @(posedge clk);
        #1;
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor / scoreboard
    bit     prev_busy = 1'b0;
    bit     have_last = 1'b0;
    longint last_cyc = 0;
    int     tally = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (det_valid_o) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R3", "unexpected decision index", det_index_o, -1);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(int'(det_index_o) == e.idx, tag, "decision index", det_index_o, e.idx);
                    chk(det_flag_o == e.flag, tag, $sformatf("flag cell %0d", e.idx),
                        det_flag_o, e.flag);
                end
                tally += det_flag_o;
                chk(int'(det_count_o) == tally, "R11", "running count", det_count_o, tally);
                if (frame_cfar && have_last)
                    chk(cyc - last_cyc == 3, "R5", "decision spacing", cyc - last_cyc, 3);
                last_cyc  = cyc;
                have_last = 1'b1;
            end
            if (prev_busy && !busy_o) begin
                int et;
                et = (tot_q.size() != 0) ? tot_q.pop_front() : -1;
                chk(det_count_o == 0, "R11", "count cleared at frame end", det_count_o, 0);
                chk(tally == et, "R11", "frame total", tally, et);
                chk(exp_q.size() == 0, "R3", "missing decisions", exp_q.size(), 0);
                mon_last_total = tally;
                tally = 0;
                have_last = 1'b0;
            end
            prev_busy = busy_o;
        end
    end

    task automatic fill_base();
        for (int i = 0; i < N; i++) d[i] = 100 + (i * 37) % 29;
        d[0] = 900; d[6] = 1500; d[7] = 400; d[19] = 1200; d[31] = 800;
    endtask

    task automatic fill_step();
        for (int i = 0; i < N; i++) d[i] = (i < 16) ? 100 + (i % 3) * 5 : 800 + (i % 4) * 7;
        d[14] = 700; d[17] = 2000; d[3] = 450;
    endtask

    initial begin
        int t1, t2;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(busy_o == 0, "R1", "busy after reset", busy_o, 0);
        chk(det_valid_o == 0, "R1", "valid after reset", det_valid_o, 0);
        chk(det_flag_o == 0, "R1", "flag after reset", det_flag_o, 0);
        chk(det_count_o == 0, "R1", "count after reset", det_count_o, 0);

        fill_base();
        run_frame(1, 0, 2, 4, 48, 0, 0, 0, "R7");
        run_frame(1, 1, 2, 4, 48, 0, 0, 0, "R8");
        run_frame(1, 2, 2, 4, 48, 0, 0, 0, "R9");
        run_frame(1, 3, 2, 4, 48, 0, 0, 0, "R9");
        run_frame(1, 0, 7, 15, 40, 0, 0, 0, "R6");
        run_frame(1, 0, 0, 1, 24, 0, 0, 0, "R6");
        run_frame(1, 1, 3, 0, 16, 0, 0, 0, "R10");
        run_frame(0, 0, 0, 0, 0, 500, 0, 0, "R4");
        run_frame(0, 0, 0, 0, 0, 899, 1, 0, "R4");
        run_frame(1, 0, 2, 4, 48, 0, 2, 1, "R2");

        fill_step();
        run_frame(1, 1, 1, 3, 40, 0, 0, 0, "R8");
        run_frame(1, 2, 1, 3, 40, 0, 0, 0, "R9");
        run_frame(1, 0, 1, 3, 40, 0, 1, 0, "R3");

        fill_base();
        run_frame(1, 0, 2, 4, 48, 0, 0, 0, "R13");
        t1 = mon_last_total;
        run_frame(1, 0, 2, 4, 48, 0, 0, 0, "R13");
        t2 = mon_last_total;
        chk(t1 == t2 && t1 >= 0, "R13", "repeat frame totals", t2, t1);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 100000, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule